// File: doc/BRIEF.md
# Tiled Text Pixel Renderer

This block converts the current raster position into one 6-bit colour for a text screen of 32 columns by 16 rows. Each character cell covers 16 by 24 screen pixels: an 8x8 glyph drawn twice as wide and three times as tall. The block contains two 512-byte dual-port memories, one for character codes and one for colour attributes. The host writes them through a single write port while the display side reads them. It also contains a glyph ROM and two copies of a 16-entry palette, one for the foreground colour and one for the background colour.

A raster timing generator outside the block supplies the horizontal and vertical pixel counts and a flag that is high inside the 512x384 text region. The renderer returns the colour for that position three clocks later, held in an output register. Outside the text region the output is black. The attribute byte of each cell selects that cell's foreground and background colours from the palette.

Top module: `text_pixel_renderer`

## Requirements
- R1: While `rst` is high, and in the clocks after it falls until the pipeline has filled, `rgb` is 0.
- R2: A position sampled at one rising edge of `clk` sets `rgb` after the third rising edge counted from that one. Before that edge, `rgb` still shows the previous position.
- R3: The cell address is (vpos / 24) * 32 + (hpos / 16). Every address from 0 to 511 maps to its own cell, and writing one cell leaves every other cell unchanged.
- R4: Inside a cell, the glyph line is (vpos mod 24) / 3 and the glyph column is (hpos mod 16) / 2. Glyph column 0 is bit 7 of the glyph byte (the leftmost pixel). Line 0 is the top line.
- R5: For a character code c below 192, the byte for glyph line l is (c + 37*l) mod 256. Codes 192 to 255 give an all-zero byte on every line.
- R6: Bits [7:4] of the attribute byte hold the foreground palette index and bits [3:0] hold the background index. A glyph bit of 1 selects the foreground colour and a bit of 0 selects the background colour.
- R7: In the colour code, bits [5:4] are blue, [3:2] green and [1:0] red. Palette entry 0 is 0x00, entry 1 is 0x3F and entry 2 is 0x03. Each entry i from 3 to 15 is (5*i + 7) mod 64.
- R8: When `active` was low for the position being shown, `rgb` is 0 whatever the memory contents.
- R9: A write with `wr_attr` low stores into the character memory, and a write with `wr_attr` high stores into the attribute memory. A write to one memory leaves the other memory's byte at that address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | 10 | Horizontal pixel count |
| vpos | input | 10 | Vertical line count |
| active | input | 1 | High inside the 512x384 text region |
| wr_en | input | 1 | Host write strobe |
| wr_attr | input | 1 | Write target: 0 character memory, 1 attribute memory |
| wr_addr | input | 9 | Cell address for the write |
| wr_data | input | 8 | Byte to write |
| rgb | output | 6 | Registered pixel colour, blue/green/red two bits each |

## Verification
The assertions assume that `active` is high only while hpos is below 512 and vpos is below 384. They also assume that every cell read while `active` is high has been written since power-up, because the memories have no reset. The stimulus writes both bytes of each cell before showing any position in it. It sets `active` only at in-range positions, and it holds each position for at least three clocks so the pipeline is full before a sample is taken. The tests write to memory while the display is showing other cells. A write to the cell being read in the same cycle is therefore never tested.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int GLYPH_W    = 8;
    localparam int GLYPH_H    = 8;
    localparam int CODE_W     = 8;
    localparam int COLOR_W    = 6;
    localparam int PAL_N      = 16;
    localparam int PAL_IDX_W  = $clog2(PAL_N);
    localparam int FONT_CHARS = 192;
    localparam int GCOL_W     = $clog2(GLYPH_W);
    localparam int GLINE_W    = $clog2(GLYPH_H);

    typedef logic [COLOR_W-1:0] color_t;

    // position-derived selects carried alongside the memory reads
    typedef struct packed {
        logic [GCOL_W-1:0]  gcol;
        logic [GLINE_W-1:0] gline;
        logic               act;
    } sel_s1_t;

    typedef struct packed {
        logic [GCOL_W-1:0]        gcol;
        logic [2*PAL_IDX_W-1:0]   attr;
        logic                     act;
    } sel_s2_t;

    // glyph byte: computed pattern for the populated codes, blank above
    function automatic logic [GLYPH_W-1:0] font_row(input logic [CODE_W-1:0] code,
                                                    input logic [GLINE_W-1:0] line);
        if (int'(code) >= FONT_CHARS)
            return '0;
        return GLYPH_W'(int'(code) + 37 * int'(line));
    endfunction

    // palette entry: fixed low entries, computed remainder
    function automatic color_t pal_color(input logic [PAL_IDX_W-1:0] idx);
        case (idx)
            PAL_IDX_W'(0): return 6'h00;
            PAL_IDX_W'(1): return 6'h3F;
            PAL_IDX_W'(2): return 6'h03;
            default:       return COLOR_W'(5 * int'(idx) + 7);
        endcase
    endfunction

endpackage

// File: rtl/tpr_dual_ram.sv
module tpr_dual_ram #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tpr_glyph_rom.sv
module tpr_glyph_rom
    import tpr_pkg::*;
(
    input  logic                 clk,
    input  logic [CODE_W-1:0]    code,
    input  logic [GLINE_W-1:0]   line,
    output logic [GLYPH_W-1:0]   row
);
    always_ff @(posedge clk) begin
        row <= font_row(code, line);
    end
endmodule

// File: rtl/tpr_palette_rom.sv
module tpr_palette_rom
    import tpr_pkg::*;
(
    input  logic [PAL_IDX_W-1:0] idx,
    output color_t               color
);
    always_comb color = pal_color(idx);
endmodule

// File: rtl/text_pixel_renderer.sv
module text_pixel_renderer
    import tpr_pkg::*;
#(
    parameter int COLS    = 32,
    parameter int ROWS    = 16,
    parameter int SCALE_X = 2,
    parameter int SCALE_Y = 3,
    parameter int POS_W   = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [POS_W-1:0]              hpos,
    input  logic [POS_W-1:0]              vpos,
    input  logic                          active,
    input  logic                          wr_en,
    input  logic                          wr_attr,
    input  logic [$clog2(COLS*ROWS)-1:0]  wr_addr,
    input  logic [7:0]                    wr_data,
    output logic [COLOR_W-1:0]            rgb
);
    localparam int CELL_W = GLYPH_W * SCALE_X;
    localparam int CELL_H = GLYPH_H * SCALE_Y;
    localparam int ADDR_W = $clog2(COLS * ROWS);
    localparam int ATTR_W = 2 * PAL_IDX_W;

    // stage 0: position decode
    logic [POS_W-1:0]  cell_col, cell_row;
    logic [ADDR_W-1:0] cell_addr;
    sel_s1_t           sel_d;

    always_comb begin
        cell_col   = POS_W'(hpos / POS_W'(CELL_W));
        cell_row   = POS_W'(vpos / POS_W'(CELL_H));
        cell_addr  = ADDR_W'(cell_row * POS_W'(COLS) + cell_col);
        sel_d.gcol  = GCOL_W'((hpos % POS_W'(CELL_W)) / POS_W'(SCALE_X));
        sel_d.gline = GLINE_W'((vpos % POS_W'(CELL_H)) / POS_W'(SCALE_Y));
        sel_d.act   = active;
    end

    // stage 1: memory reads
    logic [CODE_W-1:0] char_q;
    logic [ATTR_W-1:0] attr_q;
    logic              we_char, we_attr;

    assign we_char = wr_en & ~wr_attr;
    assign we_attr = wr_en &  wr_attr;

    tpr_dual_ram #(.DW(CODE_W), .AW(ADDR_W)) u_char_ram (
        .clk(clk), .we(we_char), .waddr(wr_addr), .wdata(wr_data),
        .raddr(cell_addr), .rdata(char_q)
    );

    tpr_dual_ram #(.DW(ATTR_W), .AW(ADDR_W)) u_attr_ram (
        .clk(clk), .we(we_attr), .waddr(wr_addr), .wdata(wr_data),
        .raddr(cell_addr), .rdata(attr_q)
    );

    sel_s1_t s1_q;
    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= sel_d;
    end

    // stage 2: glyph fetch
    logic [GLYPH_W-1:0] glyph_q;

    tpr_glyph_rom u_glyph (
        .clk(clk), .code(char_q), .line(s1_q.gline), .row(glyph_q)
    );

    sel_s2_t s2_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.gcol <= s1_q.gcol;
            s2_q.attr <= attr_q;
            s2_q.act  <= s1_q.act;
        end
    end

    // stage 3: colour resolve and output register
    logic [PAL_IDX_W-1:0] pal_idx [2];
    color_t               pal_rgb [2];
    logic                 pix_on;
    logic                 act_s2;

    assign pal_idx[0] = s2_q.attr[ATTR_W-1 -: PAL_IDX_W];
    assign pal_idx[1] = s2_q.attr[PAL_IDX_W-1:0];
    assign pix_on     = glyph_q[GLYPH_W - 1 - int'(s2_q.gcol)];
    assign act_s2     = s2_q.act;

    for (genvar g = 0; g < 2; g++) begin : g_pal
        tpr_palette_rom u_pal (.idx(pal_idx[g]), .color(pal_rgb[g]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            rgb <= '0;
        else if (!act_s2)
            rgb <= '0;
        else
            rgb <= pix_on ? pal_rgb[0] : pal_rgb[1];
    end
endmodule

// File: rtl/tpr_checks.sv
module tpr_checks
    import tpr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               active,
    input logic [COLOR_W-1:0] rgb,
    input logic [CODE_W-1:0]  char_code,
    input logic [GLYPH_W-1:0] glyph_row,
    input logic               sel_act,
    input logic [COLOR_W-1:0] fg_rgb,
    input logic [COLOR_W-1:0] bg_rgb
);
    // R1
    a_r1_reset_black: assert property (@(posedge clk)
        rst |=> rgb == '0);

    // R8 (three-stage alignment of the active flag, R2)
    a_r8_dark_outside: assert property (@(posedge clk) disable iff (rst)
        !$past(active, 3) |-> rgb == '0);

    // R5
    a_r5_blank_codes: assert property (@(posedge clk) disable iff (rst)
        (int'($past(char_code)) >= FONT_CHARS) |-> glyph_row == '0);

    // R6
    a_r6_fg_or_bg: assert property (@(posedge clk) disable iff (rst)
        $past(sel_act) |-> (rgb == $past(fg_rgb) || rgb == $past(bg_rgb)));
endmodule

bind text_pixel_renderer tpr_checks u_chk (
    .clk(clk), .rst(rst), .active(active), .rgb(rgb),
    .char_code(char_q), .glyph_row(glyph_q), .sel_act(act_s2),
    .fg_rgb(pal_rgb[0]), .bg_rgb(pal_rgb[1])
);

// File: tb/text_pixel_renderer_tb.sv
module text_pixel_renderer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] hpos = '0;
    logic [9:0] vpos = '0;
    logic       active = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_attr = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] rgb;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    text_pixel_renderer u_dut (
        .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos), .active(active),
        .wr_en(wr_en), .wr_attr(wr_attr), .wr_addr(wr_addr), .wr_data(wr_data),
        .rgb(rgb)
    );

    typedef struct packed {
        logic [9:0] h;
        logic [9:0] v;
        logic [7:0] code;
        logic [7:0] attr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'd0,   10'd0,   8'd65,  8'h12},
        '{10'd511, 10'd383, 8'd100, 8'h21},
        '{10'd17,  10'd25,  8'd77,  8'h1F},
        '{10'd46,  10'd47,  8'd150, 8'h3C},
        '{10'd200, 10'd100, 8'd191, 8'h5A},
        '{10'd300, 10'd250, 8'd200, 8'h1F},
        '{10'd86,  10'd252, 8'd0,   8'h34},
        '{10'd100, 10'd300, 8'd255, 8'hE0}
    };

    // models taken from the requirements
    function automatic logic [5:0] m_pal(input int i);
        if (i == 0) return 6'h00;
        if (i == 1) return 6'h3F;
        if (i == 2) return 6'h03;
        return 6'((5 * i + 7) % 64);
    endfunction

    function automatic logic [5:0] m_pix(input int h, input int v,
                                         input int code, input int attr, input bit act);
        int line, col, fg, bg;
        logic [7:0] row;
        if (!act) return 6'h00;
        line = (v % 24) / 3;
        col  = (h % 16) / 2;
        row  = (code < 192) ? 8'((code + 37 * line) % 256) : 8'h00;
        fg   = (attr >> 4) & 15;
        bg   = attr & 15;
        return row[7 - col] ? m_pal(fg) : m_pal(bg);
    endfunction

    function automatic int cell_of(input int h, input int v);
        return (v / 24) * 32 + (h / 16);
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_checks++;
        if (rgb !== exp) begin
            n_fail++;
            $display("FAIL %s: rgb=%h expected=%h", req, rgb, exp);
        end
    endtask

    task automatic wr(input bit to_attr, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_attr = to_attr; wr_addr = 9'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic show(input int h, input int v, input bit act);
        @(negedge clk);
        hpos = 10'(h); vpos = 10'(v); active = act;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 during reset", 6'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 6'h00);

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, cell_of(VECS[i].h, VECS[i].v), VECS[i].code);
            wr(1'b1, cell_of(VECS[i].h, VECS[i].v), VECS[i].attr);
            show(VECS[i].h, VECS[i].v, 1'b1);
            check("R3/R5/R6 table", m_pix(VECS[i].h, VECS[i].v, VECS[i].code, VECS[i].attr, 1'b1));
        end
        // R3: all cells still hold their own bytes
        for (int i = 0; i < NV; i++) begin
            show(VECS[i].h, VECS[i].v, 1'b1);
            check("R3 no aliasing", m_pix(VECS[i].h, VECS[i].v, VECS[i].code, VECS[i].attr, 1'b1));
        end

        // R8: inactive position with a bright cell
        show(0, 0, 1'b0);
        check("R8 inactive black", 6'h00);

        // R2: latency of three edges
        wr(1'b0, 70, 10); wr(1'b1, 70, 8'h11);
        show(96, 48, 1'b1);
        hpos = 10'd96; vpos = 10'd48; active = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 edge1 old", 6'h3F);
        @(posedge clk); @(negedge clk);
        check("R2 edge2 old", 6'h3F);
        @(posedge clk); @(negedge clk);
        check("R2 edge3 new", 6'h00);

        // R7: literal palette entries (fg and bg equal)
        show(96, 48, 1'b1);
        check("R7 entry1 white", 6'h3F);
        wr(1'b1, 70, 8'h22);
        show(96, 48, 1'b1);
        check("R7 entry2 red", 6'h03);
        wr(1'b1, 70, 8'h00);
        show(96, 48, 1'b1);
        check("R7 entry0 black", 6'h00);

        // R4: code 128 gives line0 = 0x80, line1 = 0xA5 ; attr fg white bg red
        wr(1'b0, 67, 128); wr(1'b1, 67, 8'h12);
        show(48, 48, 1'b1);
        check("R4 msb leftmost", 6'h3F);
        show(50, 48, 1'b1);
        check("R4 column 1", 6'h03);
        show(52, 50, 1'b1);
        check("R4 line0 column2", 6'h03);
        show(52, 51, 1'b1);
        check("R4 line1 column2", 6'h3F);

        // R9: attribute write leaves character, character write leaves attribute
        wr(1'b1, 67, 8'h1F);
        show(48, 48, 1'b1);
        check("R9 char kept", 6'h3F);
        wr(1'b0, 67, 0);
        show(48, 48, 1'b1);
        check("R9 attr kept", 6'h12);

        // R5: blank code above the font
        wr(1'b0, 67, 250);
        show(48, 48, 1'b1);
        check("R5 blank code", 6'h12);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", 6'h00);
        rst = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule